// File: doc/BRIEF.md
# Serial EEPROM Slave Read Engine

This block is the target-side protocol engine of a two-wire serial EEPROM with a 13-bit byte address (8192 locations). It oversamples the clock and data lines with the system clock, finds START, repeated START and STOP conditions, compares the incoming device address with its own, and answers by pulling the data line low through an open-drain enable. A master can read the byte under the internal address counter, choose any location through an address-only write followed by a repeated START, or keep acknowledging to stream consecutive bytes.

The address counter is kept between transactions. After any byte goes out, it holds that byte's address plus one, so a later plain read continues from where the last one stopped. The counter rolls over from 8191 to 0 inside a stream. The storage is a registered byte-wide lookup whose content is a fixed function of the address. Because the content is known, every read can be checked from the address alone. The only write path is the one that loads the counter.

Top module: `ee_read_engine`

## Requirements
- R1: After reset the open-drain enable `sda_pull_o` is 0 and the address counter is 0, so the first current-address read returns the byte at address 0.
- R2: A device-address byte whose upper seven bits equal binary 1010 followed by `dev_sel_i[2:0]` is acknowledged by a low data line during the ninth SCL pulse. Its last bit selects a read (1) or an address-setting write (0).
- R3: A device-address byte that does not match gets no acknowledge, and the engine leaves the data line released for every later clock until the next START.
- R4: In a write-mode access, the two following bytes are each acknowledged. They are taken as the memory address, high byte first. After a repeated START and a read-mode address byte, the engine returns the byte at that address. The byte stored at address A is `A[7:0] XOR {3'b000, A[12:8]}`.
- R5: The three most significant bits of the high address byte are ignored.
- R6: A read started without an address phase returns the byte at one past the last byte sent, even across STOP conditions.
- R7: When the master acknowledges a data byte, the engine sends the byte at the next address.
- R8: A stream that passes address 8191 continues at address 0.
- R9: After a data byte that the master does not acknowledge, the engine keeps the data line released until the next START or STOP.
- R10: A START or STOP in the middle of an address phase abandons it and leaves the address counter unchanged.
- R11: The engine changes its data-line drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| dev_sel_i | input | 3 | Strap value forming the low three device-address bits |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The engine sees a pad edge after two synchronizer flops. It acts on the next clock edge, so its data-line drive changes within three system clocks of an SCL fall seen at the pins. The bench holds every SCL half period for eight system clocks and changes data only four clocks after SCL falls. It samples acknowledge and data bits in the middle of the SCL high phase, long after the drive has settled. Counter effects appear only in later transactions, so they are checked through the bytes those reads return, and a monitor flags any drive change seen while SCL is high.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  // fixed upper nibble of the 7-bit device address
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         SEL_W      = 3;

  typedef enum logic [3:0] {
    ST_IDLE,     // wait for START, ignore traffic
    ST_DEV,      // shifting in device address
    ST_ACK_DEV,  // driving ack for device address
    ST_AHI,      // shifting in high address byte
    ST_ACK_HI,
    ST_ALO,      // shifting in low address byte
    ST_ACK_LO,
    ST_WAIT,     // address loaded, wait for repeated START
    ST_TX,       // shifting out a data byte
    ST_MACK      // sampling master ack/nack
  } ee_state_e;

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic [STAGES-1:0] scl_sh_n, sda_sh_n;
  logic              scl_d_q, sda_d_q;

  always_comb begin
    scl_sh_n = {scl_sh_q[STAGES-2:0], scl_i};
    sda_sh_n = {sda_sh_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sh_q <= scl_sh_n;
      sda_sh_q <= sda_sh_n;
      scl_d_q  <= scl_sh_q[STAGES-1];
      sda_d_q  <= sda_sh_q[STAGES-1];
    end
  end

  assign scl_o      = scl_sh_q[STAGES-1];
  assign sda_o      = sda_sh_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d_q;
  assign scl_fall_o = ~scl_o & scl_d_q;
  assign start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;

endmodule

// File: rtl/ee_addr_cnt.sv
module ee_addr_cnt #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] cnt_o
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | inc_i;
    cnt_n  = load_i ? load_val_i : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + ONE); // R7
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && cnt_q == '1) |=> cnt_q == '0); // R8

endmodule

// File: rtl/ee_pattern_rom.sv
module ee_pattern_rom #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    data_o
);

  logic [7:0] data_q, data_n;

  always_comb begin
    data_n = addr_i[7:0] ^ 8'(addr_i >> 8);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_n;
  end

  assign data_o = data_q;

endmodule

// File: rtl/ee_rd_ctrl.sv
module ee_rd_ctrl
  import ee_rd_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       rom_i,
  output logic             inc_o,
  output logic             load_o,
  output logic [AW-1:0]    load_val_o,
  output logic             pull_o
);

  localparam int HI_W = AW - 8;

  ee_state_e       st_q, st_n;
  logic [2:0]      bit_q, bit_n;
  logic [7:0]      sh_q, sh_n;
  logic            done_q, done_n;
  logic            rw_q, rw_n;
  logic [HI_W-1:0] hi_q, hi_n;
  logic            pull_q, pull_n;
  logic            mack_q, mack_n;
  logic            dev_hit;

  assign dev_hit = (sh_q[7:1] == {DEV_PREFIX, sel_i});

  always_comb begin
    st_n   = st_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    done_n = done_q;
    rw_n   = rw_q;
    hi_n   = hi_q;
    pull_n = pull_q;
    mack_n = mack_q;
    inc_o  = 1'b0;
    load_o = 1'b0;
    if (start_i) begin
      st_n   = ST_DEV;
      bit_n  = '0;
      done_n = 1'b0;
      pull_n = 1'b0;
    end else if (stop_i) begin
      st_n   = ST_IDLE;
      done_n = 1'b0;
      pull_n = 1'b0;
    end else begin
      case (st_q)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (scl_rise_i) begin
            sh_n  = {sh_q[6:0], sda_i};
            bit_n = bit_q + 3'd1;
            if (bit_q == 3'd7) done_n = 1'b1;
          end else if (scl_fall_i && done_q) begin
            done_n = 1'b0;
            if (st_q == ST_DEV) begin
              if (dev_hit) begin
                rw_n   = sh_q[0];
                pull_n = 1'b1;
                st_n   = ST_ACK_DEV;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st_q == ST_AHI) begin
              hi_n   = sh_q[HI_W-1:0];
              pull_n = 1'b1;
              st_n   = ST_ACK_HI;
            end else begin
              load_o = 1'b1;
              pull_n = 1'b1;
              st_n   = ST_ACK_LO;
            end
          end
        end
        ST_ACK_DEV: begin
          if (scl_fall_i) begin
            bit_n  = '0;
            done_n = 1'b0;
            if (rw_q) begin
              sh_n   = rom_i;
              pull_n = ~rom_i[7];
              st_n   = ST_TX;
            end else begin
              pull_n = 1'b0;
              st_n   = ST_AHI;
            end
          end
        end
        ST_ACK_HI: begin
          if (scl_fall_i) begin
            pull_n = 1'b0;
            bit_n  = '0;
            st_n   = ST_ALO;
          end
        end
        ST_ACK_LO: begin
          if (scl_fall_i) begin
            pull_n = 1'b0;
            st_n   = ST_WAIT;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bit_n = bit_q + 3'd1;
            if (bit_q == 3'd7) done_n = 1'b1;
          end else if (scl_fall_i) begin
            if (done_q) begin
              done_n = 1'b0;
              pull_n = 1'b0;
              inc_o  = 1'b1;
              st_n   = ST_MACK;
            end else begin
              sh_n   = {sh_q[6:0], 1'b0};
              pull_n = ~sh_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_n = ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              sh_n   = rom_i;
              pull_n = ~rom_i[7];
              bit_n  = '0;
              st_n   = ST_TX;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: begin
          pull_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      rw_q   <= 1'b0;
      hi_q   <= '0;
      pull_q <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      done_q <= done_n;
      rw_q   <= rw_n;
      hi_q   <= hi_n;
      pull_q <= pull_n;
      mack_q <= mack_n;
    end
  end

  assign load_val_o = {hi_q, sh_q};
  assign pull_o     = pull_q;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pull_q) && !$past(start_i) && !$past(stop_i)) |-> !scl_i); // R11
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MACK && scl_fall_i && !mack_q && !start_i && !stop_i)
      |=> (!pull_q && st_q == ST_IDLE)); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!pull_q && st_q == ST_IDLE)); // R10
  AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEV && done_q && scl_fall_i && !start_i && !stop_i && !dev_hit)
      |=> (!pull_q && st_q == ST_IDLE)); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> !pull_q); // R3

endmodule

// File: rtl/ee_read_engine.sv
module ee_read_engine
  import ee_rd_pkg::*;
#(
  parameter int AW          = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] dev_sel_i,
  output logic             sda_pull_o
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          inc, load;
  logic [AW-1:0] load_val, cnt;
  logic [7:0]    rom_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  ee_rd_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .sel_i      (dev_sel_i),
    .rom_i      (rom_q),
    .inc_o      (inc),
    .load_o     (load),
    .load_val_o (load_val),
    .pull_o     (sda_pull_o)
  );

  ee_addr_cnt #(.AW(AW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .inc_i      (inc),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  ee_pattern_rom #(.AW(AW)) u_rom (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .addr_i (cnt),
    .data_o (rom_q)
  );

endmodule

// File: tb/ee_read_engine_test.sv
`timescale 1ns/1ps
module ee_read_engine_test;

  localparam int HB = 4;  // quarter of an SCL period, in system clocks

  // {address[12:0], byte count[2:0]}
  localparam logic [15:0] VEC [5] = '{
    {13'h0123, 3'd2},
    {13'h1FFE, 3'd4},
    {13'h00FF, 3'd3},
    {13'h1000, 3'd1},
    {13'h0A5A, 3'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic       sda_pull;
  logic       sda_line;
  int         n_chk = 0;
  int         n_fail = 0;
  int         hi_chg = 0;
  logic       prev_pull = 1'b0;
  logic [12:0] ptr;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  ee_read_engine uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .dev_sel_i  (sel),
    .sda_pull_o (sda_pull)
  );

  // R11 monitor: drive changes seen while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_pull !== prev_pull && scl) hi_chg++;
    prev_pull = sda_pull;
  end

  function automatic logic [7:0] exp_b(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HB) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half(); half();
  endtask

  task automatic bit_cycle(input logic v, output logic s);
    sda_m = v; half(); scl = 1'b1; half(); s = sda_line; half(); scl = 1'b0; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      d[i] = s;
    end
    bit_cycle(~mack, s);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic ack;
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack); chk("R2 write-mode device ack", ack, 1);
    send_byte(hi, ack);                   chk("R4 high address ack", ack, 1);
    send_byte(lo, ack);                   chk("R4 low address ack", ack, 1);
  endtask

  // read n bytes after a (repeated) START, expect data from address a on
  task automatic read_run(input string tag, input logic [12:0] a, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack); chk("R2 read-mode device ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, d);
      chk(tag, d, exp_b(13'(a + 13'(k))));
    end
    bus_stop();
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic ack, s;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R1 drive released in reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 drive released after reset", sda_pull, 0);

    // R1/R6: current-address reads from reset
    read_run("R1 first current read at address 0", 13'd0, 1);
    read_run("R6 current read continues", 13'd1, 1);
    ptr = 13'd2;

    // vector table: random and sequential reads, including wrap
    for (int i = 0; i < 5; i++) begin
      set_addr({3'b000, VEC[i][15:11]}, VEC[i][10:3]);
      read_run("R4 R7 R8 random/sequential data", VEC[i][15:3], int'(VEC[i][2:0]));
      ptr = 13'(VEC[i][15:3] + 13'(VEC[i][2:0]));
    end
    read_run("R6 current read after table", ptr, 1);

    // R8 dedicated wrap check
    set_addr(8'h1F, 8'hFF);
    read_run("R8 wrap 8191 to 0", 13'h1FFF, 3);

    // R5 upper bits of the high byte ignored
    set_addr(8'hE2, 8'h34);
    read_run("R5 ignored high bits", 13'h0234, 2);
    ptr = 13'h0236;

    // R3 mismatched device address
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b1}, ack);
    chk("R3 mismatch not acked", ack, 0);
    for (int i = 0; i < 9; i++) begin
      bit_cycle(1'b1, s);
      chk("R3 line stays released", s, 1);
    end
    bus_stop();
    read_run("R3 counter untouched by mismatch", ptr, 1);
    ptr = ptr + 13'd1;

    // R9 release after master NACK
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack); chk("R2 read ack", ack, 1);
    read_byte(1'b0, d);                   chk("R9 data before nack", d, exp_b(ptr));
    ptr = ptr + 13'd1;
    for (int i = 0; i < 9; i++) begin
      bit_cycle(1'b1, s);
      chk("R9 released after nack", s, 1);
    end
    chk("R9 drive off after nack", sda_pull, 0);
    bus_stop();

    // R10 STOP inside the low address byte
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    send_byte(8'h07, ack);
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
    bus_stop();
    chk("R10 released after stop", sda_pull, 0);
    read_run("R10 counter kept after stop abort", ptr, 1);
    ptr = ptr + 13'd1;

    // R10 repeated START inside the high address byte
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    for (int i = 0; i < 3; i++) bit_cycle(1'b1, s);
    read_run("R10 counter kept after start abort", ptr, 1);
    ptr = ptr + 13'd1;

    // R2 new strap value
    sel = 3'b010;
    read_run("R2 match with new strap", ptr, 1);
    ptr = ptr + 13'd1;

    chk("R11 no drive change while SCL high", hi_chg, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule